// File: doc/BRIEF.md
# Tournament Branch Direction Chooser

This block predicts the direction of a conditional branch by running two direction predictors side by side and choosing between them per branch. Component 0 is a bimodal table of 2-bit saturating counters indexed by fetch address bits. Component 1 is a table of 2-bit saturating counters indexed by a register that holds the most recent resolved branch outcomes. A third table of 2-bit chooser counters, also indexed by address, records which component has been more accurate for each branch. The most significant bit of the chooser counter selects the component whose prediction becomes the final one.

Prediction is combinational. The fetch stage presents an address and gets back the final direction, both component directions, the address index and the history index that were used. When the branch resolves, the pipeline returns the address, the saved history index, the component directions seen at prediction time and the real outcome. Both components train on every update. The chooser trains only when the two components disagreed. The history register shifts in the resolved outcome at update time, so it holds no speculative state.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the history register is all zeros, so every prediction is not-taken on both components and on the final output, and pred_gidx_o is 0.
- R2: The address index is pred_pc_i[IDX_W+1:2] (the address shifted right by two and masked to IDX_W bits). It is output on pred_idx_o and used to read both the bimodal table and the chooser table.
- R3: A counter predicts taken when its bit 1 is 1. A valid update increments it on a taken outcome and decrements it on a not-taken outcome, holding at 11 and at 00.
- R4: Each valid update shifts upd_taken_i into bit 0 of the history register and moves the older bits up by one. pred_gidx_o shows the history register, and that value is the index for reading the history table.
- R5: A valid update trains the history-table counter at upd_gidx_i, not the counter at the current history.
- R6: pred_taken_o equals pred_p1_o when bit 1 of the chooser counter at the address index is 1, and equals pred_p0_o otherwise.
- R7: On a valid update with upd_p0_i different from upd_p1_i, the chooser counter at the update address increments if upd_p1_i equals upd_taken_i and decrements otherwise, with saturation. When upd_p0_i equals upd_p1_i it is unchanged.
- R8: Both component counters are trained on every valid update, whichever component was selected.
- R9: When upd_valid_i is 0, no table or history state changes, whatever the other update inputs carry.
- R10: Predict outputs in a cycle reflect the state before that cycle's update. The update becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Final direction (1 = taken) |
| pred_p0_o | output | 1 | Bimodal component direction |
| pred_p1_o | output | 1 | History component direction |
| pred_idx_o | output | IDX_W | Address index used for the bimodal and chooser tables |
| pred_gidx_o | output | HIST_W | History value used as the history-table index |
| upd_valid_i | input | 1 | Update strobe for a resolved branch |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_gidx_i | input | HIST_W | History index saved at prediction time |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_p0_i | input | 1 | Bimodal direction seen at prediction time |
| upd_p1_i | input | 1 | History direction seen at prediction time |

## Verification
The hardest case to reach is a final prediction that follows component 1 while the two components disagree. That needs a chooser counter pushed to its upper half, a bimodal counter trained one way, and a history-table entry trained the other way at the exact index the history will hold at prediction time. The stimulus first feeds disagreeing updates in which component 1 is correct, for one address. It then sends ten taken updates from a different address, all aimed at history index all-ones, so that the history reaches all-ones just as that entry saturates taken. A long run of mixed addresses and outcomes, with the predictions fed back as update inputs, then covers chooser training in both directions against a reference model.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_WEAK = ctr_t'(1);

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == CTR_MIN) ? c : c - ctr_t'(1);
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter ctr_t        RST_VAL = CTR_WEAK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];
  ctr_t wr_val;

  assign rd_ctr_o = mem_q[rd_idx_i];
  assign wr_val   = ctr_step(mem_q[wr_idx_i], wr_up_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_val;
    end
  end
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         hist_q <= '0;
        else if (shift_en_i) hist_q <= bit_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         hist_q <= '0;
        else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
      end
    end
  endgenerate

  assign hist_o = hist_q;
endmodule

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred
  import tp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic              pred_p0_o,
  output logic              pred_p1_o,
  output logic [IDX_W-1:0]  pred_idx_o,
  output logic [HIST_W-1:0] pred_gidx_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_gidx_i,
  input  logic              upd_taken_i,
  input  logic              upd_p0_i,
  input  logic              upd_p1_i
);
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [HIST_W-1:0] hist;
  ctr_t              bim_ctr, glb_ctr, meta_ctr;
  logic              meta_wr_en, meta_up;
  logic              unused_pc_bits;

  assign rd_idx = pred_pc_i[IDX_HI:IDX_LO];
  assign wr_idx = upd_pc_i[IDX_HI:IDX_LO];
  assign unused_pc_bits = ^{pred_pc_i, upd_pc_i};

  // chooser trains only on disagreement, toward the component that was right
  assign meta_wr_en = upd_valid_i && (upd_p0_i != upd_p1_i);
  assign meta_up    = (upd_p1_i == upd_taken_i);

  tp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (upd_valid_i),
    .bit_i      (upd_taken_i),
    .hist_o     (hist)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK)) u_bim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_ctr_o (bim_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (wr_idx),
    .wr_up_i  (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WEAK)) u_glb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (hist),
    .rd_ctr_o (glb_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_gidx_i),
    .wr_up_i  (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK)) u_meta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_ctr_o (meta_ctr),
    .wr_en_i  (meta_wr_en),
    .wr_idx_i (wr_idx),
    .wr_up_i  (meta_up)
  );

  assign pred_p0_o    = ctr_dir(bim_ctr);
  assign pred_p1_o    = ctr_dir(glb_ctr);
  assign pred_taken_o = ctr_dir(meta_ctr) ? pred_p1_o : pred_p0_o;
  assign pred_idx_o   = rd_idx;
  assign pred_gidx_o  = hist;
endmodule

// File: rtl/tp_checks.sv
module tp_checks #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_taken_o,
  input logic              pred_p0_o,
  input logic              pred_p1_o,
  input logic [HIST_W-1:0] pred_gidx_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic              upd_taken_i
);
  assert_hist_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_gidx_o == {$past(pred_gidx_o[HIST_W-2:0]), $past(upd_taken_i)});

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(pred_gidx_o));

  assert_agree_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_p0_o == pred_p1_o) |-> (pred_taken_o == pred_p0_o));

  assert_taken_keeps_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && pred_p0_o &&
     upd_pc_i[IDX_W+1:2] == pred_pc_i[IDX_W+1:2])
    |=> (pred_pc_i[IDX_W+1:2] != $past(pred_pc_i[IDX_W+1:2])) || pred_p0_o);
endmodule

bind tourney_dir_pred tp_checks #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_pc_i    (pred_pc_i),
  .pred_taken_o (pred_taken_o),
  .pred_p0_o    (pred_p0_o),
  .pred_p1_o    (pred_p1_o),
  .pred_gidx_o  (pred_gidx_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i)
);

// File: tb/tourney_dir_pred_test.sv
`timescale 1ns/1ps
module tourney_dir_pred_test;
  localparam int PC_W = 32, IDX_W = 10, HIST_W = 10;
  localparam int DEPTH = 1 << IDX_W;
  localparam int GDEPTH = 1 << HIST_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [PC_W-1:0]   pred_pc_i = '0;
  logic              pred_taken_o, pred_p0_o, pred_p1_o;
  logic [IDX_W-1:0]  pred_idx_o;
  logic [HIST_W-1:0] pred_gidx_o;
  logic              upd_valid_i = 1'b0;
  logic [PC_W-1:0]   upd_pc_i = '0;
  logic [HIST_W-1:0] upd_gidx_i = '0;
  logic              upd_taken_i = 1'b0, upd_p0_i = 1'b0, upd_p1_i = 1'b0;

  always #4 clk = ~clk;

  tourney_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pred_pc_i(pred_pc_i),
    .pred_taken_o(pred_taken_o), .pred_p0_o(pred_p0_o), .pred_p1_o(pred_p1_o),
    .pred_idx_o(pred_idx_o), .pred_gidx_o(pred_gidx_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_gidx_i(upd_gidx_i),
    .upd_taken_i(upd_taken_i), .upd_p0_i(upd_p0_i), .upd_p1_i(upd_p1_i)
  );

  // reference model
  logic [1:0]        m_bim  [DEPTH];
  logic [1:0]        m_glb  [GDEPTH];
  logic [1:0]        m_meta [DEPTH];
  logic [HIST_W-1:0] m_hist;

  typedef struct {
    logic              fin, p0, p1;
    logic [IDX_W-1:0]  idx;
    logic [HIST_W-1:0] gidx;
    string             tag;
  } exp_t;
  exp_t sb[$];

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic exp_t model_pred(input logic [PC_W-1:0] pc, input string tag);
    exp_t e;
    e.idx  = pc[IDX_W+1:2];
    e.gidx = m_hist;
    e.p0   = m_bim[e.idx][1];
    e.p1   = m_glb[m_hist][1];
    e.fin  = m_meta[e.idx][1] ? e.p1 : e.p0;
    e.tag  = tag;
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_bim[i] = 2'b01; m_meta[i] = 2'b01; end
    for (int i = 0; i < GDEPTH; i++) m_glb[i] = 2'b01;
    m_hist = '0;
  endtask

  // driver: drive one cycle, push the expected prediction, advance the model
  task automatic step(input logic [PC_W-1:0] pc, input bit v, input logic [PC_W-1:0] upc,
                      input logic [HIST_W-1:0] ug, input bit t, input bit q0, input bit q1,
                      input string tag);
    logic [IDX_W-1:0] wi;
    @(negedge clk);
    pred_pc_i = pc; upd_valid_i = v; upd_pc_i = upc; upd_gidx_i = ug;
    upd_taken_i = t; upd_p0_i = q0; upd_p1_i = q1;
    sb.push_back(model_pred(pc, tag));
    if (v) begin
      wi = upc[IDX_W+1:2];
      m_bim[wi] = sat(m_bim[wi], t);
      m_glb[ug] = sat(m_glb[ug], t);
      if (q0 != q1) m_meta[wi] = sat(m_meta[wi], q1 == t);
      m_hist = {m_hist[HIST_W-2:0], t};
    end
  endtask

  // predict and resolve the same branch, feeding predictions back
  task automatic run(input logic [PC_W-1:0] pc, input bit t, input string tag);
    exp_t e;
    e = model_pred(pc, tag);
    step(pc, 1'b1, pc, m_hist, t, e.p0, e.p1, tag);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare ports late in each cycle, before the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "final", pred_taken_o, e.fin);
        chk(e.tag, "p0",    pred_p0_o,    e.p0);
        chk(e.tag, "p1",    pred_p1_o,    e.p1);
        chk(e.tag, "idx",   pred_idx_o,   e.idx);
        chk(e.tag, "gidx",  pred_gidx_o,  e.gidx);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] PC_M = 32'h0000_0400;
  localparam logic [PC_W-1:0] PC_N = 32'h0000_0880;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    step(32'h0, 0, 0, 0, 0, 0, 0, "R1_reset");
    step(32'hFFFF_FFFC, 0, 0, 0, 0, 0, 0, "R1_reset_top");
    // R2: index from address bits [11:2]
    step(32'h0000_1234, 0, 0, 0, 0, 0, 0, "R2_index");
    step(32'hABCD_EF07, 0, 0, 0, 0, 0, 0, "R2_index_hi");

    // R3: bimodal saturation up then one step down
    for (int i = 0; i < 4; i++) run(32'h0000_0100, 1'b1, "R3_train_up");
    run(32'h0000_0100, 1'b0, "R3_one_down");
    step(32'h0000_0100, 0, 0, 0, 0, 0, 0, "R3_still_taken");
    for (int i = 0; i < 4; i++) run(32'h0000_0100, 1'b0, "R3_train_down");
    step(32'h0000_0100, 0, 0, 0, 0, 0, 0, "R3_floor");

    // R7 and R6: chooser favours component 1 while components disagree
    step(PC_M, 1, PC_M, 10'h000, 1'b0, 1'b1, 1'b0, "R7_meta_inc");
    step(PC_M, 1, PC_M, 10'h000, 1'b0, 1'b1, 1'b0, "R7_meta_inc2");
    for (int i = 0; i < 10; i++) step(PC_N, 1, PC_N, 10'h3FF, 1'b1, 1'b0, 1'b0, "R5_R8_glb_train");
    step(PC_M, 0, 0, 0, 0, 0, 0, "R6_select_p1");
    step(PC_N, 0, 0, 0, 0, 0, 0, "R6_select_p0");
    // R9: idle cycle with live update fields changes nothing
    step(PC_M, 0, PC_M, 10'h3FF, 1'b0, 1'b0, 1'b1, "R9_idle");
    step(PC_M, 0, 0, 0, 0, 0, 0, "R9_after_idle");
    // R7: agreeing updates leave chooser alone, then component 0 wins it back
    for (int i = 0; i < 3; i++) step(PC_M, 1, PC_M, 10'h155, 1'b1, 1'b0, 1'b0, "R7_agree_hold");
    step(PC_M, 0, 0, 0, 0, 0, 0, "R7_after_agree");
    step(PC_M, 1, PC_M, 10'h155, 1'b1, 1'b1, 1'b0, "R7_meta_dec");
    step(PC_M, 1, PC_M, 10'h155, 1'b1, 1'b1, 1'b0, "R7_meta_dec2");
    step(PC_M, 0, 0, 0, 0, 0, 0, "R7_back_to_p0");
    // R10: same-cycle predict sees old state, next cycle sees new
    step(32'h0000_0200, 1, 32'h0000_0200, 10'h0AA, 1'b1, 1'b0, 1'b0, "R10_same_cycle");
    step(32'h0000_0200, 1, 32'h0000_0200, 10'h0AA, 1'b1, 1'b0, 1'b0, "R10_same_cycle2");
    step(32'h0000_0200, 0, 0, 0, 0, 0, 0, "R10_visible");
    // R4: history shift pattern
    run(32'h0000_0300, 1'b1, "R4_hist_a");
    run(32'h0000_0300, 1'b0, "R4_hist_b");
    run(32'h0000_0300, 1'b1, "R4_hist_c");
    step(32'h0000_0300, 0, 0, 0, 0, 0, 0, "R4_hist_check");

    // R8: mixed traffic with alternating and biased branches
    for (int i = 0; i < 600; i++) begin
      logic [PC_W-1:0] pc;
      bit t;
      pc = {20'h0, 2'(i % 4), 8'h40, 2'b00} ^ {$urandom_range(0, 3), 4'h0, 2'b00};
      case (i % 4)
        0: t = 1'b1;
        1: t = i[2];
        2: t = ($urandom_range(0, 9) != 0);
        default: t = $urandom_range(0, 1);
      endcase
      run(pc, t, "R8_mixed");
    end
    step(32'h0, 0, 0, 0, 0, 0, 0, "R8_final");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule